// File: doc/BRIEF.md
# NOR Flash Multi-Sector Erase Controller

This block is the command front end and erase engine of a parallel NOR flash array with a small set of equal-sized sectors. Software reaches it through a synchronous bus. A write strobe carries an address and a data byte. A read strobe returns a byte one cycle later. A separate `tick` enable sets the time base, and all time intervals are counted in ticks.

A six-write unlock sequence arms a sector erase. The first sector erase command opens an acceptance window. While the window is open, more sector erase commands can be written without unlocking again. Each one adds its sector to a one-bit-per-sector erase set and restarts the window. When the window runs out, one erase runs for every sector in the set. Its duration grows with the number of distinct sectors. During the window and the erase, reads return a status byte instead of array data.

The controller is a single state machine with eight states:
- `ST_READ` (idle, read-array).
- `ST_UNL1`, `ST_UNL2`, `ST_SETUP`, `ST_UNL4` and `ST_UNL5` for the unlock sequence.
- `ST_WINDOW`, while further commands are accepted.
- `ST_ERASING`.

The transitions are:
- Each expected byte steps the machine forward: `ST_READ` to `ST_UNL1` on 0xAA, then 0x55 to `ST_UNL2`, 0x80 to `ST_SETUP`, 0xAA to `ST_UNL4`, 0x55 to `ST_UNL5`, and 0x30 to `ST_WINDOW`.
- Any other byte in an unlock state goes back to `ST_READ`.
- In `ST_WINDOW`, 0x30 stays in the state and any other byte aborts to `ST_READ`.
- The window timeout moves `ST_WINDOW` to `ST_ERASING`.
- The erase timeout moves `ST_ERASING` to `ST_READ`.

Top module: `nor_erase_ctrl`

## Requirements
- R1: After reset the block is in read-array mode. A read strobe returns, on the next cycle, the byte stored at `addr`. The initial content of word w is (0x40 + w) mod 256.
- R2: The writes 0xAA, 0x55, 0x80, 0xAA, 0x55, 0x30 open the acceptance window. The addresses of the first five writes are ignored. For the final 0x30, the upper address bits (addr divided by WORDS_PER_SECTOR) select the sector. While the window is open, a read returns status with bit 3 (DQ3) equal to 0.
- R3: Each 0x30 written while the window is open adds the addressed sector to the erase set. It also restarts the window, which lasts WINDOW_US*TICKS_PER_US ticks.
- R4: Any value other than 0x30 written while the window is open aborts the operation. The block returns to read-array mode, empties the erase set, and erases nothing.
- R5: When the window expires, DQ3 reads 1 and the erase runs for K*(2^ERASE_EXP)*1000*TICKS_PER_US ticks. K is the number of distinct queued sectors, so a sector written twice counts once.
- R6: The status byte is made up as follows:
  - Bit 7 (DQ7) reads 0 during the window and the erase.
  - Bit 6 (DQ6) inverts on each successive status read.
  - All other bits read 0 apart from DQ3.
  - Once read-array mode returns, successive reads of one word are equal.
- R7: Writes made during the erase are ignored. This includes unlock sequences, 0x30 and 0xF0.
- R8: When the erase completes, every queued sector reads 0xFF and every other sector keeps its contents. The erase set is cleared and the block returns to read-array mode.
- R9: A byte that does not match the next expected unlock or command byte, 0xF0 included, returns the decoder to idle. A later sequence must then start again from 0xAA.
- R10: Timers advance only on cycles where `tick` is 1. With `tick` held at 0, the window stays open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable, TICKS_PER_US pulses per microsecond |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address for reads and sector erase commands |
| wr_data | input | 8 | Command or data byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read result, valid the cycle after `rd_en` |

## Verification
The bench erases with several command patterns, and each pattern separates a different fault:
- A second sector written 40 ticks after the first, then read 40 ticks later, shows whether the window restarts. A fixed window would already be closed at that read.
- A repeated write to the same sector is timed against one sector's erase period. This shows whether duplicates are counted twice.
- The two-sector erase is timed past one sector's period, which shows whether the duration scales with the sector count.
- A broken unlock sequence, an abort byte in the window, unlock writes and 0xF0 during an erase, and a window held open with `tick` low each confirm, by reading the array afterwards, that nothing was erased that should not have been.

// File: rtl/nfe_pkg.sv
`timescale 1ns/1ps
package nfe_pkg;
    typedef enum logic [2:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_SETUP, ST_UNL4, ST_UNL5, ST_WINDOW, ST_ERASING
    } nfe_state_e;

    localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
    localparam logic [7:0] CODE_SETUP    = 8'h80;
    localparam logic [7:0] CODE_SECTOR   = 8'h30;
    localparam logic [7:0] ERASED_BYTE   = 8'hFF;
    localparam logic [7:0] INIT_BASE     = 8'h40;
endpackage

// File: rtl/nfe_cmd_fsm.sv
`timescale 1ns/1ps
module nfe_cmd_fsm
    import nfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       timer_done,
    output nfe_state_e state_q,
    output logic       accept,
    output logic       abort,
    output logic       start_erase,
    output logic       erase_done
);
    nfe_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        accept      = 1'b0;
        abort       = 1'b0;
        start_erase = 1'b0;
        erase_done  = 1'b0;
        unique case (state_q)
            ST_READ: begin
                if (wr_en && wr_data == CODE_UNLOCK_A) state_d = ST_UNL1;
            end
            ST_UNL1: begin
                if (wr_en) state_d = (wr_data == CODE_UNLOCK_B) ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
                if (wr_en) state_d = (wr_data == CODE_SETUP) ? ST_SETUP : ST_READ;
            end
            ST_SETUP: begin
                if (wr_en) state_d = (wr_data == CODE_UNLOCK_A) ? ST_UNL4 : ST_READ;
            end
            ST_UNL4: begin
                if (wr_en) state_d = (wr_data == CODE_UNLOCK_B) ? ST_UNL5 : ST_READ;
            end
            ST_UNL5: begin
                if (wr_en) begin
                    if (wr_data == CODE_SECTOR) begin
                        accept  = 1'b1;
                        state_d = ST_WINDOW;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_WINDOW: begin
                if (wr_en) begin
                    if (wr_data == CODE_SECTOR) begin
                        accept = 1'b1;
                    end else begin
                        abort   = 1'b1;
                        state_d = ST_READ;
                    end
                end else if (timer_done) begin
                    start_erase = 1'b1;
                    state_d     = ST_ERASING;
                end
            end
            ST_ERASING: begin
                if (timer_done) begin
                    erase_done = 1'b1;
                    state_d    = ST_READ;
                end
            end
            default: state_d = ST_READ;
        endcase
    end
endmodule

// File: rtl/nfe_timer.sv
`timescale 1ns/1ps
module nfe_timer #(
    parameter int CNT_W        = 32,
    parameter int WINDOW_TICKS = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_window,
    input  logic             load_erase,
    input  logic [CNT_W-1:0] erase_ticks,
    output logic             done
);
    localparam logic [CNT_W-1:0] WIN_V = CNT_W'(WINDOW_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign done = run_q && tick && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_window) begin
            cnt_q <= WIN_V;
            run_q <= 1'b1;
        end else if (load_erase) begin
            cnt_q <= erase_ticks;
            run_q <= 1'b1;
        end else if (done) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (run_q && tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/nfe_array.sv
`timescale 1ns/1ps
module nfe_array
    import nfe_pkg::*;
#(
    parameter int NUM_SECTORS      = 4,
    parameter int WORDS_PER_SECTOR = 4,
    parameter int ADDR_W           = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   erase_en,
    input  logic [NUM_SECTORS-1:0] erase_mask,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [7:0]             rd_word
);
    localparam int TOTAL_WORDS = NUM_SECTORS * WORDS_PER_SECTOR;

    logic [7:0] words [TOTAL_WORDS];

    for (genvar w = 0; w < TOTAL_WORDS; w++) begin : g_word
        localparam logic [7:0] INIT_V = 8'(int'(INIT_BASE) + w);
        localparam int         SECT   = w / WORDS_PER_SECTOR;
        logic [7:0] cell_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                           cell_q <= INIT_V;
            else if (erase_en && erase_mask[SECT]) cell_q <= ERASED_BYTE;
        end
        assign words[w] = cell_q;
    end

    assign rd_word = words[rd_addr];
endmodule

// File: rtl/nor_erase_ctrl.sv
`timescale 1ns/1ps
module nor_erase_ctrl
    import nfe_pkg::*;
#(
    parameter int NUM_SECTORS      = 4,
    parameter int WORDS_PER_SECTOR = 4,
    parameter int TICKS_PER_US     = 50,
    parameter int WINDOW_US        = 50,
    parameter int ERASE_EXP        = 9,
    parameter int ADDR_W           = $clog2(NUM_SECTORS * WORDS_PER_SECTOR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data
);
    localparam int CNT_W        = 32;
    localparam int WORD_AW      = $clog2(WORDS_PER_SECTOR);
    localparam int SECT_AW      = ADDR_W - WORD_AW;
    localparam int WINDOW_TICKS = WINDOW_US * TICKS_PER_US;
    localparam logic [CNT_W-1:0] SECTOR_TICKS =
        CNT_W'((2 ** ERASE_EXP) * 1000 * TICKS_PER_US);

    nfe_state_e             state_q;
    logic                   accept, abort, start_erase, erase_done, timer_done;
    logic [NUM_SECTORS-1:0] erase_set_q;
    logic [CNT_W-1:0]       erase_ticks;
    logic [SECT_AW-1:0]     sect_idx;
    logic [7:0]             array_word;
    logic                   busy;
    logic                   toggle_q;

    assign sect_idx    = addr[ADDR_W-1:WORD_AW];
    assign busy        = (state_q == ST_WINDOW) || (state_q == ST_ERASING);
    assign erase_ticks = CNT_W'($countones(erase_set_q)) * SECTOR_TICKS;

    nfe_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .timer_done(timer_done), .state_q(state_q), .accept(accept),
        .abort(abort), .start_erase(start_erase), .erase_done(erase_done)
    );

    nfe_timer #(.CNT_W(CNT_W), .WINDOW_TICKS(WINDOW_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_window(accept),
        .load_erase(start_erase), .erase_ticks(erase_ticks), .done(timer_done)
    );

    nfe_array #(
        .NUM_SECTORS(NUM_SECTORS), .WORDS_PER_SECTOR(WORDS_PER_SECTOR), .ADDR_W(ADDR_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .erase_en(erase_done), .erase_mask(erase_set_q),
        .rd_addr(addr), .rd_word(array_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                   erase_set_q <= '0;
        else if (abort || erase_done) erase_set_q <= '0;
        else if (accept)              erase_set_q <= erase_set_q | (NUM_SECTORS'(1) << sect_idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            toggle_q <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rd_data  <= {1'b0, toggle_q, 2'b00, (state_q == ST_ERASING), 3'b000};
                toggle_q <= ~toggle_q;
            end else begin
                rd_data <= array_word;
            end
        end
    end
endmodule

// File: rtl/nor_erase_ctrl_chk.sv
`timescale 1ns/1ps
module nor_erase_ctrl_chk
    import nfe_pkg::*;
#(
    parameter int NUM_SECTORS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input nfe_state_e             st,
    input logic                   rd_en,
    input logic [7:0]             rd_data,
    input logic                   wr_en,
    input logic [7:0]             wr_data,
    input logic [NUM_SECTORS-1:0] erase_set,
    input logic                   accept
);
    a_r2_dq3_low_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_WINDOW) |=> !rd_data[3]);

    a_r5_dq3_high_erasing: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_ERASING) |=> rd_data[3]);

    a_r6_dq7_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (st == ST_WINDOW || st == ST_ERASING)) |=> !rd_data[7]);

    a_r3_accept_adds: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st == ST_WINDOW && erase_set != '0));

    a_r4_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WINDOW && wr_en && wr_data != CODE_SECTOR) |=> (st == ST_READ && erase_set == '0));

    a_r7_erase_ignores_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASING) |=> ((st == ST_ERASING && $stable(erase_set)) ||
                                (st == ST_READ && erase_set == '0)));
endmodule

bind nor_erase_ctrl nor_erase_ctrl_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(state_q), .rd_en(rd_en), .rd_data(rd_data),
    .wr_en(wr_en), .wr_data(wr_data), .erase_set(erase_set_q), .accept(accept)
);

// File: tb/nor_erase_ctrl_bench.sv
`timescale 1ns/1ps
module nor_erase_ctrl_bench;
    localparam int NS  = 4;
    localparam int WPS = 4;
    localparam int AW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nor_erase_ctrl #(
        .NUM_SECTORS(NS), .WORDS_PER_SECTOR(WPS), .TICKS_PER_US(1),
        .WINDOW_US(50), .ERASE_EXP(0)
    ) u_nor_erase_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    function automatic logic [7:0] pat(input int w);
        return 8'(8'h40 + w);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(input int a, input logic [7:0] d);
        addr = AW'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input int a, output logic [7:0] d);
        addr = AW'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic erase_seq(input int sector);
        do_wr(0, 8'hAA); do_wr(0, 8'h55); do_wr(0, 8'h80);
        do_wr(0, 8'hAA); do_wr(0, 8'h55); do_wr(sector * WPS, 8'h30);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        do_rd(0, r);  check("R1 word0", r, pat(0));
        do_rd(5, r);  check("R1 word5", r, pat(5));
        do_rd(15, r); check("R1 word15", r, pat(15));
    endtask

    task automatic t_partial();
        logic [7:0] r;
        do_wr(0, 8'hAA); do_wr(0, 8'h55); do_wr(0, 8'hF0);
        do_wr(0, 8'h80); do_wr(0, 8'hAA); do_wr(0, 8'h55); do_wr(0, 8'h30);
        do_rd(0, r); check("R9 broken sequence stays read-array", r, pat(0));
        idle(60);
        do_rd(1, r); check("R9 no erase after broken sequence", r, pat(1));
        do_wr(0, 8'hAA); do_wr(0, 8'h55); do_wr(0, 8'h80);
        do_wr(0, 8'hAA); do_wr(0, 8'h55); do_wr(0, 8'hF0);
        do_rd(2, r); check("R9 F0 at last step returns to read", r, pat(2));
    endtask

    task automatic t_multi();
        logic [7:0] r, r2;
        erase_seq(0);
        do_rd(0, r);
        check("R2 DQ3 low in window", r & 8'h08, 8'h00);
        check("R6 DQ7 low in window", r & 8'h80, 8'h00);
        idle(38);
        do_wr(1 * WPS, 8'h30);
        idle(38);
        do_rd(8, r);
        check("R3 window restarted by second sector", r & 8'h08, 8'h00);
        idle(15);
        do_rd(0, r);
        do_rd(4, r2);
        check("R5 DQ3 high while erasing", r & 8'h08, 8'h08);
        check("R6 DQ7 low while erasing", r & 8'h80, 8'h00);
        check("R6 DQ6 inverts between reads", (r ^ r2) & 8'h40, 8'h40);
        check("R6 status other bits zero", r2 & 8'h37, 8'h00);
        idle(1700);
        do_rd(0, r);
        check("R5 two-sector erase still running past one period", r & 8'h88, 8'h08);
        idle(400);
        for (int w = 0; w < NS * WPS; w++) begin
            do_rd(w, r);
            check($sformatf("R8 word %0d after multi erase", w), r, (w < 2 * WPS) ? 8'hFF : pat(w));
        end
        do_rd(0, r); do_rd(0, r2);
        check("R6 DQ6 stopped toggling", r2, r);
    endtask

    task automatic t_dup_ignore();
        logic [7:0] r;
        erase_seq(2);
        do_wr(8, 8'h30);
        do_wr(9, 8'h30);
        idle(60);
        do_rd(8, r); check("R5 erasing after dup window", r & 8'h08, 8'h08);
        erase_seq(3);
        do_wr(12, 8'hF0);
        do_rd(12, r); check("R7 writes ignored during erase", r & 8'h88, 8'h08);
        idle(850);
        do_rd(8, r); check("R5 single-sector erase still running", r & 8'h88, 8'h08);
        idle(250);
        do_rd(8, r);  check("R5 duplicate counted once, sector2 erased", r, 8'hFF);
        do_rd(11, r); check("R8 sector2 last word erased", r, 8'hFF);
        do_rd(12, r); check("R7 sector3 untouched by ignored command", r, pat(12));
    endtask

    task automatic t_abort();
        logic [7:0] r;
        erase_seq(3);
        do_wr(12, 8'h00);
        do_rd(12, r); check("R4 abort returns read-array", r, pat(12));
        idle(1200);
        do_rd(13, r); check("R4 aborted sector not erased", r, pat(13));
    endtask

    task automatic t_tick();
        logic [7:0] r;
        tick = 1'b0;
        erase_seq(3);
        idle(200);
        do_rd(12, r); check("R10 window held open without ticks", r & 8'h88, 8'h00);
        tick = 1'b1;
        idle(60);
        do_rd(12, r); check("R10 window closes once ticks resume", r & 8'h08, 8'h08);
        idle(1100);
        do_rd(12, r); check("R10 sector3 erased", r, 8'hFF);
        do_rd(15, r); check("R10 sector3 last word erased", r, 8'hFF);
        do_rd(0, r);  check("R8 earlier erased sector stays erased", r, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_partial();
        t_multi();
        t_dup_ignore();
        t_abort();
        t_tick();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule